// File: doc/BRIEF.md
# Router Port Flit History Buffer

This block is a debug probe for a network-on-chip router. It keeps a separate rolling history for every router input port and for the local output port. Whenever a port's flit-valid strobe is high, the block copies that flit, with its virtual-channel identifier and its flit-type code, into the history of that port. Once a history is full, each new flit pushes out the oldest one. After a failure has been detected, raising `freeze` stops capture on every port, so the recorded traffic stays intact for inspection.

A host reads the histories through a small request/response stream. It sends an address on a valid/ready request channel, and the block returns one data word on a valid/ready response channel. At most one response is outstanding at a time. A new request is accepted only while the response slot is empty, or in the same cycle that the pending response is taken. While the response is held by back-pressure, both the request channel and the response data stay frozen. The capture inputs are pure observation taps and have no back-pressure.

A design-time switch removes all capture storage. In that build the read channel still answers every request, and every answer is zero.

Top module: `flit_history_buffer`

## Requirements
- R1: Each of the NUM_IN input ports and the local output port (history number NUM_IN) has its own independent history. On a clock edge where a port's valid strobe is high and `freeze` is low, one entry is written into that port's history and no other history changes. Several ports may capture in the same cycle.
- R2: A stored entry is the 37-bit value {flit_type[1:0], vc_id[2:0], payload[31:0]}, with the type in the top bits. It is zero-extended to RD_W bits on the read data bus.
- R3: Entry index 0 is the newest flit of a port, and index k is the flit captured k captures earlier. When a history already holds DEPTH entries, a new capture discards the oldest entry.
- R4: Each port has a fill count that starts at 0, rises by one per capture and saturates at DEPTH.
- R5: Read address layout: bits [IDX_W-1:0] give the entry index, bits [IDX_W+PORT_W-1:IDX_W] give the port number, and the top bit selects the fill count (1) instead of an entry (0). In a fill read the index bits are ignored.
- R6: A read returns zero if its entry index is not below that port's fill count, or if its port number is NUM_IN+1 or higher.
- R7: While `freeze` is high, no history and no fill count changes on any port. Reads are still served.
- R8: A request is accepted on an edge where `rd_req_valid` and `rd_req_ready` are both high. `rd_rsp_valid` is high on the following cycle and carries the lookup for the state before that edge. `rd_req_ready` equals NOT `rd_rsp_valid` OR `rd_rsp_ready`. While `rd_rsp_valid` is high and `rd_rsp_ready` is low, the response stays valid and its data stays stable.
- R9: After reset, every fill count is 0 and no response is pending (`rd_rsp_valid` low, `rd_req_ready` high).
- R10: With CAPTURE_EN = 0, no capture storage exists. Every read still follows the R8 handshake and returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Stops capture on all ports |
| in_valid | input | NUM_IN | Flit-valid strobe per input port |
| in_payload | input | NUM_IN*32 | Flit payload per input port, port p at bits [p*32+:32] |
| in_vc | input | NUM_IN*3 | Virtual-channel identifier per input port |
| in_type | input | NUM_IN*2 | Flit-type code per input port |
| lo_valid | input | 1 | Flit-valid strobe of the local output port |
| lo_payload | input | 32 | Local output payload |
| lo_vc | input | 3 | Local output virtual-channel identifier |
| lo_type | input | 2 | Local output flit type |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request can be accepted |
| rd_req_addr | input | ADDR_W | Read address, layout per R5 |
| rd_rsp_valid | output | 1 | Read response valid |
| rd_rsp_ready | input | 1 | Host takes the response |
| rd_rsp_data | output | RD_W | Read response data |

## Verification
The bench builds one instance with two input ports and a depth of 8. Twelve captures on port 0 are then enough to drive that history past wrap-around and into fill saturation, and the port field still has one unused code for the out-of-range read. A second instance with the same small geometry but CAPTURE_EN = 0 shares the read stimulus, so the zero-only variant is checked against the same handshake. Simultaneous captures on several ports, a frozen cycle with all strobes active, and a stalled response with a waiting request cover the port isolation, freeze and back-pressure rules.

// File: rtl/fhb_pkg.sv
package fhb_pkg;
  localparam int PAYLOAD_W = 32;
  localparam int VC_W      = 3;
  localparam int TYPE_W    = 2;
  localparam int ENTRY_W   = TYPE_W + VC_W + PAYLOAD_W;

  typedef struct packed {
    logic [TYPE_W-1:0]    flit_type;
    logic [VC_W-1:0]      vc_id;
    logic [PAYLOAD_W-1:0] payload;
  } fhb_entry_t;
endpackage

// File: rtl/fhb_port_history.sv
module fhb_port_history #(
  parameter int DEPTH   = 64,
  parameter int ENTRY_W = 37,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flit_valid,
  input  logic               freeze,
  input  logic [ENTRY_W-1:0] flit_entry,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic [CNT_W-1:0]   fill
);
  logic [ENTRY_W-1:0] store [DEPTH];
  logic [IDX_W-1:0]   wptr;
  logic [IDX_W-1:0]   slot;
  logic               cap;

  assign cap = flit_valid && !freeze;

  // circular storage: behaves as a shift register seen from the read side
  always_ff @(posedge clk) begin
    if (cap) store[wptr] <= flit_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      fill <= '0;
    end else if (cap) begin
      wptr <= wptr + IDX_W'(1);
      if (fill != CNT_W'(DEPTH)) fill <= fill + CNT_W'(1);
    end
  end

  // index 0 is the newest entry
  assign slot = wptr - IDX_W'(1) - rd_idx;

  always_comb begin
    rd_entry = '0;
    if ({1'b0, rd_idx} < fill) rd_entry = store[slot];
  end

  assert_freeze_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(fill) && $stable(wptr)));

  assert_fill_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != $past(fill)) |-> (fill == $past(fill) + CNT_W'(1)));

  assert_fill_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CNT_W'(DEPTH)) |=> (fill == CNT_W'(DEPTH)));
endmodule

// File: rtl/fhb_read_mux.sv
module fhb_read_mux #(
  parameter int NPORT   = 6,
  parameter int ENTRY_W = 37,
  parameter int IDX_W   = 6,
  parameter int RD_W    = 64,
  localparam int PORT_W = $clog2(NPORT),
  localparam int CNT_W  = IDX_W + 1,
  localparam int ADDR_W = 1 + PORT_W + IDX_W
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NPORT*ENTRY_W-1:0] entries,
  input  logic [NPORT*CNT_W-1:0]   fills,
  output logic [IDX_W-1:0]         idx,
  output logic [RD_W-1:0]          lookup
);
  logic [PORT_W-1:0] port_sel;
  logic              fill_sel;

  assign idx      = addr[IDX_W-1:0];
  assign port_sel = addr[IDX_W +: PORT_W];
  assign fill_sel = addr[ADDR_W-1];

  always_comb begin
    lookup = '0;
    if (int'(port_sel) < NPORT) begin
      if (fill_sel) lookup = RD_W'(fills[port_sel*CNT_W +: CNT_W]);
      else          lookup = RD_W'(entries[port_sel*ENTRY_W +: ENTRY_W]);
    end
  end
endmodule

// File: rtl/fhb_read_ctrl.sv
module fhb_read_ctrl #(
  parameter int RD_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [RD_W-1:0] lookup,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [RD_W-1:0] rsp_data
);
  logic accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= lookup;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_accept_answers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !req_ready) |=> $stable(rsp_data));
endmodule

// File: rtl/flit_history_buffer.sv
module flit_history_buffer
  import fhb_pkg::*;
#(
  parameter int NUM_IN     = 5,
  parameter int DEPTH      = 64,
  parameter int RD_W       = 64,
  parameter bit CAPTURE_EN = 1'b1,
  localparam int NPORT  = NUM_IN + 1,
  localparam int PORT_W = $clog2(NPORT),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = IDX_W + 1,
  localparam int ADDR_W = 1 + PORT_W + IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        freeze,
  input  logic [NUM_IN-1:0]           in_valid,
  input  logic [NUM_IN*PAYLOAD_W-1:0] in_payload,
  input  logic [NUM_IN*VC_W-1:0]      in_vc,
  input  logic [NUM_IN*TYPE_W-1:0]    in_type,
  input  logic                        lo_valid,
  input  logic [PAYLOAD_W-1:0]        lo_payload,
  input  logic [VC_W-1:0]             lo_vc,
  input  logic [TYPE_W-1:0]           lo_type,
  input  logic                        rd_req_valid,
  output logic                        rd_req_ready,
  input  logic [ADDR_W-1:0]           rd_req_addr,
  output logic                        rd_rsp_valid,
  input  logic                        rd_rsp_ready,
  output logic [RD_W-1:0]             rd_rsp_data
);
  logic [RD_W-1:0] lookup;

  generate
    if (CAPTURE_EN) begin : g_capture
      logic [NPORT*ENTRY_W-1:0] entries;
      logic [NPORT*CNT_W-1:0]   fills;
      logic [IDX_W-1:0]         idx;

      for (genvar p = 0; p < NPORT; p++) begin : g_port
        fhb_entry_t ent;
        logic       v;
        if (p < NUM_IN) begin : g_in
          assign v   = in_valid[p];
          assign ent = '{flit_type: in_type[p*TYPE_W +: TYPE_W],
                         vc_id:     in_vc[p*VC_W +: VC_W],
                         payload:   in_payload[p*PAYLOAD_W +: PAYLOAD_W]};
        end else begin : g_local
          assign v   = lo_valid;
          assign ent = '{flit_type: lo_type, vc_id: lo_vc, payload: lo_payload};
        end

        fhb_port_history #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) i_hist (
          .clk       (clk),
          .rst_n     (rst_n),
          .flit_valid(v),
          .freeze    (freeze),
          .flit_entry(ent),
          .rd_idx    (idx),
          .rd_entry  (entries[p*ENTRY_W +: ENTRY_W]),
          .fill      (fills[p*CNT_W +: CNT_W])
        );
      end

      fhb_read_mux #(.NPORT(NPORT), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .RD_W(RD_W)) i_mux (
        .addr   (rd_req_addr),
        .entries(entries),
        .fills  (fills),
        .idx    (idx),
        .lookup (lookup)
      );
    end else begin : g_bypass
      assign lookup = '0;

      assert_off_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rsp_valid |-> (rd_rsp_data == '0));
    end
  endgenerate

  fhb_read_ctrl #(.RD_W(RD_W)) i_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(rd_req_valid),
    .req_ready(rd_req_ready),
    .lookup   (lookup),
    .rsp_valid(rd_rsp_valid),
    .rsp_ready(rd_rsp_ready),
    .rsp_data (rd_rsp_data)
  );

  assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_rsp_valid) |-> rd_req_ready);
endmodule

// File: tb/test_flit_history_buffer.sv
`timescale 1ns/1ps
module test_flit_history_buffer;
  localparam int NI = 2;
  localparam int D  = 8;
  localparam int NP = NI + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freeze = 1'b0;
  logic [NI-1:0] in_valid = '0;
  logic [NI*32-1:0] in_payload = '0;
  logic [NI*3-1:0] in_vc = '0;
  logic [NI*2-1:0] in_type = '0;
  logic lo_valid = 1'b0;
  logic [31:0] lo_payload = '0;
  logic [2:0] lo_vc = '0;
  logic [1:0] lo_type = '0;
  logic rd_req_valid = 1'b0;
  logic [5:0] rd_req_addr = '0;
  logic rd_rsp_ready = 1'b1;
  logic rd_req_ready, rd_rsp_valid;
  logic [63:0] rd_rsp_data;
  logic off_req_ready, off_rsp_valid;
  logic [63:0] off_rsp_data;

  always #4 clk = ~clk;

  flit_history_buffer #(.NUM_IN(NI), .DEPTH(D)) i_flit_history_buffer (
    .clk(clk), .rst_n(rst_n), .freeze(freeze),
    .in_valid(in_valid), .in_payload(in_payload), .in_vc(in_vc), .in_type(in_type),
    .lo_valid(lo_valid), .lo_payload(lo_payload), .lo_vc(lo_vc), .lo_type(lo_type),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data));

  flit_history_buffer #(.NUM_IN(NI), .DEPTH(D), .CAPTURE_EN(1'b0)) i_off (
    .clk(clk), .rst_n(rst_n), .freeze(freeze),
    .in_valid(in_valid), .in_payload(in_payload), .in_vc(in_vc), .in_type(in_type),
    .lo_valid(lo_valid), .lo_payload(lo_payload), .lo_vc(lo_vc), .lo_type(lo_type),
    .rd_req_valid(rd_req_valid), .rd_req_ready(off_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(off_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(off_rsp_data));

  typedef struct packed {
    logic [2:0]  m;
    logic [31:0] pay;
    logic [2:0]  vc;
    logic [1:0]  ty;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{3'b001, 32'h1000_0001, 3'd1, 2'd0}, '{3'b011, 32'h1000_0002, 3'd2, 2'd1},
    '{3'b001, 32'h1000_0003, 3'd3, 2'd2}, '{3'b101, 32'h1000_0004, 3'd4, 2'd3},
    '{3'b001, 32'h1000_0005, 3'd5, 2'd0}, '{3'b111, 32'h1000_0006, 3'd6, 2'd1},
    '{3'b001, 32'h1000_0007, 3'd7, 2'd2}, '{3'b001, 32'h1000_0008, 3'd0, 2'd3},
    '{3'b011, 32'h1000_0009, 3'd1, 2'd0}, '{3'b001, 32'h1000_000A, 3'd2, 2'd1},
    '{3'b001, 32'h1000_000B, 3'd3, 2'd2}, '{3'b001, 32'h1000_000C, 3'd4, 2'd3}
  };

  logic [36:0] mdl [NP][D];
  int mdl_fill [NP];
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [36:0] mk(input int p, input logic [31:0] pay,
                                     input logic [2:0] vc, input logic [1:0] ty);
    logic [2:0] v = vc + 3'(p);
    return {ty, v, pay ^ (32'(p) << 24)};
  endfunction

  // R1: one capture cycle; model updated only when capture is expected
  task automatic drive(input logic [2:0] m, input logic [31:0] pay, input logic [2:0] vc,
                       input logic [1:0] ty, input bit upd);
    @(negedge clk);
    for (int p = 0; p < NI; p++) begin
      in_valid[p] = m[p];
      in_payload[p*32 +: 32] = pay ^ (32'(p) << 24);
      in_vc[p*3 +: 3] = vc + 3'(p);
      in_type[p*2 +: 2] = ty;
    end
    lo_valid = m[2];
    lo_payload = pay ^ (32'(2) << 24);
    lo_vc = vc + 3'd2;
    lo_type = ty;
    @(posedge clk);
    @(negedge clk);
    in_valid = '0;
    lo_valid = 1'b0;
    if (upd) begin
      for (int p = 0; p < NP; p++) begin
        if (m[p]) begin
          for (int k = D - 1; k > 0; k--) mdl[p][k] = mdl[p][k-1];
          mdl[p][0] = mk(p, pay, vc, ty);
          if (mdl_fill[p] < D) mdl_fill[p]++;
        end
      end
    end
  endtask

  task automatic do_read(input logic [5:0] a, output logic [63:0] d, output logic [63:0] doff);
    @(negedge clk);
    rd_req_valid = 1'b1;
    rd_req_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_req_valid = 1'b0;
    check("R8 response valid", 64'(rd_rsp_valid), 64'd1);
    d = rd_rsp_data;
    doff = off_rsp_data;
  endtask

  function automatic logic [5:0] eaddr(input int p, input int i);
    return {1'b0, 2'(p), 3'(i)};
  endfunction

  function automatic logic [5:0] faddr(input int p);
    return {1'b1, 2'(p), 3'd5};
  endfunction

  initial begin
    logic [63:0] d, doff;
    for (int p = 0; p < NP; p++) begin
      mdl_fill[p] = 0;
      for (int k = 0; k < D; k++) mdl[p][k] = '0;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 rsp_valid in reset", 64'(rd_rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 req_ready after reset", 64'(rd_req_ready), 64'd1);
    for (int p = 0; p < NP; p++) begin
      do_read(faddr(p), d, doff);
      check("R9 fill zero after reset", d, 64'd0);
    end
    do_read(eaddr(0, 0), d, doff);
    check("R6 empty history reads zero", d, 64'd0);

    // R1 R2 R3: vector table of captures, then full readback
    foreach (VECS[n]) drive(VECS[n].m, VECS[n].pay, VECS[n].vc, VECS[n].ty, 1'b1);
    for (int p = 0; p < NP; p++) begin
      for (int i = 0; i < D; i++) begin
        do_read(eaddr(p, i), d, doff);
        check("R3 R6 entry readback", d, (i < mdl_fill[p]) ? 64'(mdl[p][i]) : 64'd0);
        if (p == 0 && i == 0) check("R10 disabled capture reads zero", doff, 64'd0);
      end
    end
    // R2: explicit field positions of the newest local-port entry
    do_read(eaddr(2, 0), d, doff);
    check("R2 type field", 64'(d[36:35]), 64'd1);
    check("R2 vc field", 64'(d[34:32]), 64'(3'(6 + 2)));
    check("R2 zero extension", 64'(d[63:37]), 64'd0);
    // R4 R5: fill counts, port 0 saturated at depth
    do_read(faddr(0), d, doff);
    check("R4 fill saturates", d, 64'(D));
    do_read(faddr(1), d, doff);
    check("R4 fill port1", d, 64'd3);
    do_read(faddr(2), d, doff);
    check("R4 R5 fill local port", d, 64'd2);
    // R6: out-of-range port
    do_read(eaddr(3, 0), d, doff);
    check("R6 port out of range", d, 64'd0);
    do_read(faddr(3), d, doff);
    check("R6 fill of port out of range", d, 64'd0);

    // R7: freeze blocks capture, reads still served
    @(negedge clk);
    freeze = 1'b1;
    drive(3'b111, 32'hDEAD_0000, 3'd5, 2'd1, 1'b0);
    do_read(faddr(1), d, doff);
    check("R7 fill unchanged when frozen", d, 64'd3);
    do_read(eaddr(2, 0), d, doff);
    check("R7 newest entry unchanged when frozen", d, 64'(mdl[2][0]));
    do_read(eaddr(0, 0), d, doff);
    check("R7 port0 newest unchanged", d, 64'(mdl[0][0]));
    @(negedge clk);
    freeze = 1'b0;
    drive(3'b010, 32'h2000_0001, 3'd3, 2'd2, 1'b1);
    do_read(eaddr(1, 0), d, doff);
    check("R1 capture resumes after freeze", d, 64'(mdl[1][0]));
    do_read(eaddr(0, 0), d, doff);
    check("R1 other port untouched", d, 64'(mdl[0][0]));

    // R8: back-pressure
    @(negedge clk);
    rd_rsp_ready = 1'b0;
    rd_req_valid = 1'b1;
    rd_req_addr = faddr(1);
    @(posedge clk);
    @(negedge clk);
    rd_req_valid = 1'b1;
    rd_req_addr = faddr(0);
    check("R8 stalled rsp valid", 64'(rd_rsp_valid), 64'd1);
    check("R8 stalled req_ready low", 64'(rd_req_ready), 64'd0);
    check("R8 stalled data", rd_rsp_data, 64'd4);
    @(posedge clk);
    @(negedge clk);
    check("R8 data held under stall", rd_rsp_data, 64'd4);
    check("R10 handshake matches when disabled", 64'(off_rsp_valid), 64'd1);
    rd_rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_req_valid = 1'b0;
    check("R8 waiting request taken on release", rd_rsp_data, 64'(D));
    check("R8 rsp valid after release", 64'(rd_rsp_valid), 64'd1);
    check("R10 disabled data zero", off_rsp_data, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8 response drained", 64'(rd_rsp_valid), 64'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule